// File: doc/BRIEF.md
# Bus Ready and Reset Synchronizer

This block brings a bus wait-state request and a system reset request into the timing domain of the processor clock. Two ready sources feed it. Each source is paired with its own active-low enable, and a source only counts while its enable is low. The qualified sources are ORed, and the result passes through a chain of two flip-flops: the first captures on the rising clock edge and the second on the falling clock edge. A mode input chooses how many stages are used. With two stages the path is safe for a ready source that is asynchronous to the clock. With one stage the latency is shorter for a source that already meets the clock's setup time.

The reset request is active low. It is captured on the falling clock edge and comes out as an active-high reset. That reset is released on the first falling edge after the request goes back high. While the reset output is active, the ready output is forced low and both ready flip-flops are cleared. The synchronized reset is therefore the only reset the block needs.

Top module: `bus_ready_reset_sync`

## Requirements
- R1: A ready input bit `rdy_in[i]` counts only while its enable `rdy_en_n[i]` is 0. With the enable at 1, that source cannot make `rdy_o` high.
- R2: The combined ready is the OR of the qualified sources. Any single qualified source at 1 drives `rdy_o` to 1 once the path has settled.
- R3: With `sync_sel_i` = 1 (one stage), `rdy_o` takes the new combined ready value at the first falling clock edge after an input change made just after a rising edge.
- R4: With `sync_sel_i` = 0 (two stages), the combined ready is captured at a rising edge and reaches `rdy_o` at the following falling edge. An input change made just after a rising edge therefore reaches `rdy_o` at the second falling edge, and the first falling edge still shows the old value.
- R5: `rst_o` becomes 1 at the first falling clock edge that samples `rst_req_n` at 0.
- R6: `rst_o` returns to 0 at the first falling clock edge that samples `rst_req_n` at 1, and stays at 1 until that edge.
- R7: `rdy_o` is 0 whenever `rst_o` is 1, whatever the ready inputs are.
- R8: Toggling the ready input of a disabled source leaves `rdy_o` unchanged, on every falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; rising and falling edges both used |
| rst_req_n | input | 1 | Reset request, active low |
| rdy_in | input | NUM_SRC | Ready request per source, active high |
| rdy_en_n | input | NUM_SRC | Enable per source, active low |
| sync_sel_i | input | 1 | 1 = one-stage ready path, 0 = two-stage path |
| rdy_o | output | 1 | Synchronized ready |
| rst_o | output | 1 | Synchronized reset, active high |

## Verification
The hardest case to reach is the one-edge difference between the two modes. The latency only differs when an input changes in the half period between a rising edge and the next falling edge. So every stimulus step is driven just after a rising edge, and the output is sampled after each of the next two falling edges. This shows whether the old or the new value appears first. Random steps also change the mode and the enables together, so the bench reaches the case where a mode switch meets a first-stage value captured under the previous mode. Directed steps assert reset while ready is high, to check that the output is forced low at once.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic {
        SYNC_TWO_STAGE = 1'b0,
        SYNC_ONE_STAGE = 1'b1
    } sync_mode_e;

    typedef struct packed {
        logic rdy;
        logic rst;
    } sync_out_t;

    // value loaded into the falling-edge stage
    function automatic logic fall_stage_next(input sync_mode_e mode,
                                             input logic rise_val,
                                             input logic comb_val);
        return (mode == SYNC_ONE_STAGE) ? comb_val : rise_val;
    endfunction

endpackage

// File: rtl/rdy_qualify.sv
module rdy_qualify #(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] rdy_in,
    input  logic [NUM_SRC-1:0] rdy_en_n,
    output logic               rdy_any
);
    logic [NUM_SRC-1:0] qual;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign qual[g] = rdy_in[g] & ~rdy_en_n[g];
    end

    assign rdy_any = |qual;
endmodule

// File: rtl/rdy_sync_chain.sv
module rdy_sync_chain
    import brs_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  sync_mode_e mode,
    input  logic       rdy_comb,
    output logic       rdy_sync
);
    logic rise_q;
    logic fall_q;

    always_ff @(posedge clk) begin
        if (clr) rise_q <= 1'b0;
        else     rise_q <= rdy_comb;
    end

    always_ff @(negedge clk) begin
        if (clr) fall_q <= 1'b0;
        else     fall_q <= fall_stage_next(mode, rise_q, rdy_comb);
    end

    assign rdy_sync = fall_q;
endmodule

// File: rtl/rst_sync_cell.sv
module rst_sync_cell (
    input  logic clk,
    input  logic req_n,
    output logic rst_q
);
    always_ff @(negedge clk) begin
        rst_q <= ~req_n;
    end
endmodule

// File: rtl/bus_ready_reset_sync.sv
module bus_ready_reset_sync
    import brs_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_req_n,
    input  logic [NUM_SRC-1:0] rdy_in,
    input  logic [NUM_SRC-1:0] rdy_en_n,
    input  logic               sync_sel_i,
    output logic               rdy_o,
    output logic               rst_o
);
    logic       rdy_any;
    logic       rdy_sync;
    logic       rst_q;
    sync_mode_e mode;
    sync_out_t  outs;

    assign mode = sync_mode_e'(sync_sel_i);

    rdy_qualify #(.NUM_SRC(NUM_SRC)) u_qual (
        .rdy_in  (rdy_in),
        .rdy_en_n(rdy_en_n),
        .rdy_any (rdy_any)
    );

    rst_sync_cell u_rst (
        .clk  (clk),
        .req_n(rst_req_n),
        .rst_q(rst_q)
    );

    rdy_sync_chain u_chain (
        .clk     (clk),
        .clr     (rst_q),
        .mode    (mode),
        .rdy_comb(rdy_any),
        .rdy_sync(rdy_sync)
    );

    always_comb begin
        outs.rst = rst_q;
        outs.rdy = rdy_sync & ~rst_q;
    end

    assign rdy_o = outs.rdy;
    assign rst_o = outs.rst;
endmodule

// File: rtl/bus_ready_reset_sync_chk.sv
module bus_ready_reset_sync_chk #(
    parameter int NUM_SRC = 2
) (
    input logic               clk,
    input logic               rst_req_n,
    input logic [NUM_SRC-1:0] rdy_in,
    input logic [NUM_SRC-1:0] rdy_en_n,
    input logic               sync_sel_i,
    input logic               rdy_o,
    input logic               rst_o
);
    logic [1:0] fall_cnt = 2'd0;
    logic       started  = 1'b0;
    logic       qual_rise = 1'b0;
    logic       qual_now;

    assign qual_now = |(rdy_in & ~rdy_en_n);

    always_ff @(negedge clk) begin
        if (fall_cnt != 2'd3) fall_cnt <= fall_cnt + 2'd1;
        started <= (fall_cnt == 2'd3);
    end

    always_ff @(posedge clk) qual_rise <= qual_now;

    AST_RST_GATES_RDY: assert property (@(negedge clk) disable iff (!started)
        rst_o |-> !rdy_o); // R7

    AST_RST_ASSERT: assert property (@(negedge clk) disable iff (!started)
        !rst_req_n |=> rst_o); // R5

    AST_RST_RELEASE: assert property (@(negedge clk) disable iff (!started)
        rst_req_n |=> !rst_o); // R6

    AST_ONE_STAGE_LAT: assert property (@(negedge clk) disable iff (!started)
        (sync_sel_i && rst_req_n && !rst_o) |=> (rdy_o == $past(qual_now))); // R3

    AST_TWO_STAGE_LAT: assert property (@(negedge clk) disable iff (!started)
        (!sync_sel_i && rst_req_n && !rst_o) |=> (rdy_o == $past(qual_rise))); // R4
endmodule

bind bus_ready_reset_sync bus_ready_reset_sync_chk #(.NUM_SRC(NUM_SRC)) i_chk (
    .clk       (clk),
    .rst_req_n (rst_req_n),
    .rdy_in    (rdy_in),
    .rdy_en_n  (rdy_en_n),
    .sync_sel_i(sync_sel_i),
    .rdy_o     (rdy_o),
    .rst_o     (rst_o)
);

// File: tb/test_bus_ready_reset_sync.sv
`timescale 1ns/100ps
module test_bus_ready_reset_sync;
    localparam int NSRC = 2;

    logic            clk = 1'b0;
    logic            rst_req_n;
    logic [NSRC-1:0] rdy_in;
    logic [NSRC-1:0] rdy_en_n;
    logic            sync_sel_i;
    logic            rdy_o;
    logic            rst_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic exp_cur = 1'b0;

    always #2 clk = ~clk;

    bus_ready_reset_sync #(.NUM_SRC(NSRC)) i_bus_ready_reset_sync (
        .clk(clk), .rst_req_n(rst_req_n), .rdy_in(rdy_in), .rdy_en_n(rdy_en_n),
        .sync_sel_i(sync_sel_i), .rdy_o(rdy_o), .rst_o(rst_o)
    );

    function automatic logic model_qual(input logic [NSRC-1:0] r, input logic [NSRC-1:0] e);
        logic acc = 1'b0;
        for (int i = 0; i < NSRC; i++) if (r[i] && !e[i]) acc = 1'b1;
        return acc;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic after_rise(); @(posedge clk); #0.5; endtask
    task automatic after_fall(); @(negedge clk); #0.5; endtask

    // one stimulus step with latency checks at the next two falling edges
    task automatic step(input logic [NSRC-1:0] r, input logic [NSRC-1:0] e,
                        input logic sel, input string req);
        logic nv;
        logic prev;
        prev = exp_cur;
        nv   = model_qual(r, e);
        after_rise();
        rdy_in = r; rdy_en_n = e; sync_sel_i = sel;
        after_fall();
        check(req, rdy_o, sel ? nv : prev);
        after_fall();
        check(req, rdy_o, nv);
        after_fall();
        exp_cur = nv;
    endtask

    initial begin
        rst_req_n = 1'b0; rdy_in = '1; rdy_en_n = '0; sync_sel_i = 1'b0;
        void'($urandom(32'd20251));
        repeat (3) after_fall();
        check("R5", rst_o, 1'b1);
        check("R7", rdy_o, 1'b0);

        // release: still held until the falling edge
        after_rise();
        rst_req_n = 1'b1; rdy_in = '0; rdy_en_n = '1;
        check("R6", rst_o, 1'b1);
        after_fall();
        check("R6", rst_o, 1'b0);
        repeat (3) after_fall();
        check("R1", rdy_o, 1'b0);
        exp_cur = 1'b0;

        // directed latency per mode and qualification
        step(2'b01, 2'b10, 1'b1, "R3");
        step(2'b00, 2'b10, 1'b1, "R3");
        step(2'b10, 2'b01, 1'b0, "R4");
        step(2'b00, 2'b00, 1'b0, "R4");
        step(2'b11, 2'b11, 1'b0, "R1");
        step(2'b11, 2'b11, 1'b1, "R1");
        step(2'b10, 2'b00, 1'b0, "R2");
        step(2'b11, 2'b10, 1'b1, "R2");

        // disabled source toggling is ignored
        step(2'b00, 2'b01, 1'b1, "R8");
        for (int k = 0; k < 8; k++) begin
            after_rise();
            rdy_in[0] = ~rdy_in[0];
            after_fall();
            check("R8", rdy_o, 1'b0);
        end
        rdy_in = '0;
        step(2'b00, 2'b10, 1'b0, "R8");
        for (int k = 0; k < 8; k++) begin
            after_rise();
            rdy_in[1] = ~rdy_in[1];
            after_fall();
            check("R8", rdy_o, 1'b0);
        end
        rdy_in = '0;
        exp_cur = 1'b0;

        // reset while ready is high
        step(2'b01, 2'b00, 1'b1, "R3");
        after_rise();
        rst_req_n = 1'b0;
        after_fall();
        check("R5", rst_o, 1'b1);
        check("R7", rdy_o, 1'b0);
        after_fall();
        check("R7", rdy_o, 1'b0);
        after_rise();
        rst_req_n = 1'b1;
        after_fall();
        check("R6", rst_o, 1'b0);
        repeat (3) after_fall();
        check("R2", rdy_o, 1'b1);
        exp_cur = 1'b1;

        // random steps
        for (int k = 0; k < 200; k++) begin
            logic [NSRC-1:0] r;
            logic [NSRC-1:0] e;
            logic s;
            r = NSRC'($urandom);
            e = NSRC'($urandom);
            s = 1'($urandom);
            step(r, e, s, s ? "R3" : "R4");
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule